// File: doc/BRIEF.md
# ACPI Power-Management Event Block

This block holds the fixed power-management registers of a PC chipset. It has a free-running timer, a status word, an enable word and a control word. Software reaches all of them through a small word-wide register port with a write strobe and a combinational read path. When any enabled event is pending, the block holds its system control interrupt (SCI) line high. It turns software sleep requests into single-cycle shutdown or reset request pulses. It also takes two inputs from outside: a power-button event, and a strobe carrying an APM command byte that switches SCI delivery on or off.

The timer advances by one on each cycle in which the external tick enable is high, and it wraps at its width. The timer-overflow flag is armed against a half-range boundary of the counter. When software clears the flag, the boundary is moved to the next half-range multiple above the current count. Timer width is a parameter, 24 bits by default, which puts the half-range boundary at 0x800000.

Top module: `pm_event_block`

## Requirements
- R1: After reset, the status, enable, control and timer offsets all read 0, SCI is low, both request pulses are low, and the first overflow point is 2^(TMR_W-1).
- R2: The timer at offset 0x08 increases by one on each clock with tick_en high, holds otherwise, wraps at 2^TMR_W, and reads with zeros above bit TMR_W-1. Writes to offset 0x08 change nothing.
- R3: Status bit 0 (timer flag) becomes 1 on the clock after the running tick count reaches the armed overflow point, which is a multiple of 2^(TMR_W-1). It stays 1 until cleared.
- R4: Status at offset 0x00 holds bits 15 (wake), 8 (button) and 0 (timer), and every other bit reads 0. Writing 1 to a bit clears it and writing 0 leaves it. Clearing bit 0 while it is set moves the overflow point to the smallest multiple of 2^(TMR_W-1) that is above the current count. An event that sets a bit wins over a clear in the same cycle.
- R5: sci_out is high exactly while status AND enable is nonzero over bits 10, 8, 5 and 0.
- R6: A write to control at offset 0x04 stores all 16 bits except bit 13, which always reads 0.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 gives shutdown_req high for exactly the next cycle.
- R8: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 and 8 and gives reset_req high for exactly the next cycle.
- R9: A control write with bit 13 set and bits 12:10 from 2 to 7 produces no pulse and no status change.
- R10: An APM strobe with byte 0xF1 sets control bit 0, and one with 0xF0 clears it. Other bytes leave it unchanged. The strobe overrides bit 0 of a control write made in the same cycle.
- R11: A power-button event sets status bit 8 only when enable bit 8 is 1.
- R12: Enable at offset 0x02 stores and reads back all 16 bits. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer advances on cycles where this is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| pwr_btn_evt | input | 1 | Power-button event, one cycle |
| apm_cmd_vld | input | 1 | APM command strobe |
| apm_cmd | input | 8 | APM command byte |
| sci_out | output | 1 | Level SCI request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request after a fake resume |

## Verification
The hardest case to reach is the overflow re-arm. The flag must be set, and then cleared at a count that sits on the far side of the counter's wrap, so the new boundary is the wrapped value 0. The bench builds the DUT with a 10-bit timer so that whole boundary periods fit in a short run. It then steers the tick count directly: it stops ticking just before a boundary, clears the flag, and counts the exact number of ticks up to the wrap. A behavioural model keeps an unbounded tick count and target. That model runs alongside random register traffic and is compared on every clock.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;

  // register byte offsets
  localparam int OFS_STS = 'h00;
  localparam int OFS_EN  = 'h02;
  localparam int OFS_CTL = 'h04;
  localparam int OFS_TMR = 'h08;

  // bit positions shared by status and enable
  localparam int B_TMR  = 0;
  localparam int B_GBL  = 5;
  localparam int B_BTN  = 8;
  localparam int B_RTC  = 10;
  localparam int B_WAK  = 15;

  // control word fields
  localparam int B_SCI_ON = 0;
  localparam int B_SLP_GO = 13;
  localparam int SLP_TYP_LO = 10;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    SLP_POWER_OFF   = 3'd0,
    SLP_FAKE_RESUME = 3'd1
  } slp_typ_e;

  // status bits that have storage
  function automatic logic [REG_W-1:0] sts_impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_TMR] = 1'b1;
    m[B_BTN] = 1'b1;
    m[B_WAK] = 1'b1;
    return m;
  endfunction

  // event bits that can raise the interrupt
  function automatic logic [REG_W-1:0] sci_src_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_TMR] = 1'b1;
    m[B_GBL] = 1'b1;
    m[B_BTN] = 1'b1;
    m[B_RTC] = 1'b1;
    return m;
  endfunction

  function automatic logic sci_level(input logic [REG_W-1:0] sts,
                                     input logic [REG_W-1:0] en);
    return |(sts & en & sci_src_mask());
  endfunction
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rearm,
  output logic [TMR_W-1:0] count,
  output logic             hit
);
  localparam int LOW_W = TMR_W - 1;

  logic tgt_msb;

  // next half-range boundary above a count: only its top bit differs
  function automatic logic next_tgt_msb(input logic [TMR_W-1:0] c);
    return ~c[TMR_W-1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick_en) begin
      count <= count + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_msb <= 1'b1;
    end else if (rearm) begin
      tgt_msb <= next_tgt_msb(count);
    end
  end

  assign hit = (count[LOW_W-1:0] == '0) && (count[TMR_W-1] == tgt_msb);
endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             apm_vld,
  input  logic [7:0]       apm_cmd,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] ctl_d;
  logic [REG_W-1:0] keep_mask;

  always_comb begin
    keep_mask = '1;
    keep_mask[B_SLP_GO] = 1'b0;
    ctl_d = wr_ctl ? (wdata & keep_mask) : ctl_q;
    if (apm_vld && apm_cmd == APM_SCI_ON) begin
      ctl_d[B_SCI_ON] = 1'b1;
    end else if (apm_vld && apm_cmd == APM_SCI_OFF) begin
      ctl_d[B_SCI_ON] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  slp_typ_e typ,
  output logic     fake_resume,
  output logic     shutdown_req,
  output logic     reset_req
);
  logic go_off;

  assign go_off      = go && (typ == SLP_POWER_OFF);
  assign fake_resume = go && (typ == SLP_FAKE_RESUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      shutdown_req <= go_off;
      reset_req    <= fake_resume;
    end
  end
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_evt_pkg::*;
#(
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pwr_btn_evt,
  input  logic              apm_cmd_vld,
  input  logic [7:0]        apm_cmd,
  output logic              sci_out,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR);

  // named internal events
  logic             wr_sts, wr_en, wr_ctl;
  logic [REG_W-1:0] w1c;
  logic             tmr_rearm;
  logic             tmr_hit;
  logic             slp_go;
  slp_typ_e         slp_typ;
  logic             fake_resume;
  logic             btn_take;
  logic [REG_W-1:0] sts_set;

  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [TMR_W-1:0] tmr_count;

  assign wr_sts = reg_wr && (reg_addr == A_STS);
  assign wr_en  = reg_wr && (reg_addr == A_EN);
  assign wr_ctl = reg_wr && (reg_addr == A_CTL);

  assign w1c       = wr_sts ? reg_wdata : '0;
  assign tmr_rearm = sts_q[B_TMR] && w1c[B_TMR];
  assign slp_go    = wr_ctl && reg_wdata[B_SLP_GO];
  assign slp_typ   = slp_typ_e'(reg_wdata[SLP_TYP_LO +: 3]);
  assign btn_take  = pwr_btn_evt && en_q[B_BTN];

  pm_tick_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rearm   (tmr_rearm),
    .count   (tmr_count),
    .hit     (tmr_hit)
  );

  pm_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl),
    .wdata   (reg_wdata),
    .apm_vld (apm_cmd_vld),
    .apm_cmd (apm_cmd),
    .ctl_q   (ctl_q)
  );

  pm_sleep_decode u_slp (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (slp_go),
    .typ          (slp_typ),
    .fake_resume  (fake_resume),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req)
  );

  // status: sets win over write-one-to-clear
  always_comb begin
    sts_set = '0;
    sts_set[B_TMR] = tmr_hit && !tmr_rearm;
    sts_set[B_BTN] = fake_resume || btn_take;
    sts_set[B_WAK] = fake_resume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~w1c) | sts_set) & sts_impl_mask();
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= reg_wdata;
    end
  end

  assign sci_out = sci_level(sts_q, en_q);

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = DATA_W'(sts_q);
      A_EN:    reg_rdata = DATA_W'(en_q);
      A_CTL:   reg_rdata = DATA_W'(ctl_q);
      A_TMR:   reg_rdata = DATA_W'(tmr_count);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pm_event_chk.sv
module pm_event_chk
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [TMR_W-1:0] tmr_count,
  input logic             tmr_hit,
  input logic             tmr_rearm,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] ctl_q,
  input logic             apm_cmd_vld,
  input logic [7:0]       apm_cmd,
  input logic             shutdown_req,
  input logic             reset_req
);
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tmr_count == TMR_W'($past(tmr_count) + TMR_W'(1)));

  a_r2_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tmr_count));

  a_r3_hit_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_hit && !tmr_rearm) |=> sts_q[B_TMR]);

  a_r6_no_sleep_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[B_SLP_GO]);

  a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> !reset_req);

  a_r8_wake_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (sts_q[B_WAK] && sts_q[B_BTN]));

  a_r10_apm_on: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_cmd_vld && apm_cmd == APM_SCI_ON) |=> ctl_q[B_SCI_ON]);

  a_r10_apm_off: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_cmd_vld && apm_cmd == APM_SCI_OFF) |=> !ctl_q[B_SCI_ON]);
endmodule

bind pm_event_block pm_event_chk #(.TMR_W(TMR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .tmr_count    (tmr_count),
  .tmr_hit      (tmr_hit),
  .tmr_rearm    (tmr_rearm),
  .sts_q        (sts_q),
  .ctl_q        (ctl_q),
  .apm_cmd_vld  (apm_cmd_vld),
  .apm_cmd      (apm_cmd),
  .shutdown_req (shutdown_req),
  .reset_req    (reset_req)
);

// File: tb/sim_pm_event_block.sv
module sim_pm_event_block;
  localparam int TW   = 10;
  localparam int HALF = 1 << (TW - 1);
  localparam int WRAP = 1 << TW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwr_btn_evt = 1'b0;
  logic        apm_cmd_vld = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic        sci_out, shutdown_req, reset_req;

  always #2 clk = ~clk;

  pm_event_block #(.TMR_W(TW), .ADDR_W(4), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_btn_evt(pwr_btn_evt),
    .apm_cmd_vld(apm_cmd_vld), .apm_cmd(apm_cmd),
    .sci_out(sci_out), .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: unbounded tick count and overflow target
  int          m_ticks, m_tgt;
  logic [15:0] m_sts, m_en, m_ctl;
  logic        m_shut, m_rst;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return {16'h0, m_sts};
      4'h2: return {16'h0, m_en};
      4'h4: return {16'h0, m_ctl};
      4'h8: return 32'(m_ticks % WRAP);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [3:0] a);
    case (a)
      4'h0: return "R4 status read";
      4'h2: return "R12 enable read";
      4'h4: return "R6 control read";
      4'h8: return "R2 timer read";
      default: return "R12 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] clr, setv, nsts;
    bit rearm, go;
    int typ;
    if (!rst_n) begin
      m_ticks = 0; m_tgt = HALF;
      m_sts = 0; m_en = 0; m_ctl = 0;
      m_shut = 0; m_rst = 0;
    end else begin
      clr   = (reg_wr && reg_addr == 4'h0) ? reg_wdata : 16'h0;
      rearm = m_sts[0] && clr[0];
      setv  = 16'h0;
      if (!rearm && m_ticks >= m_tgt) setv[0] = 1'b1;
      if (rearm) m_tgt = ((m_ticks + HALF) / HALF) * HALF;
      go  = reg_wr && reg_addr == 4'h4 && reg_wdata[13];
      typ = int'(reg_wdata[12:10]);
      m_shut = go && typ == 0;
      m_rst  = go && typ == 1;
      if (m_rst) setv = setv | 16'h8100;
      if (pwr_btn_evt && m_en[8]) setv[8] = 1'b1;
      nsts = ((m_sts & ~clr) | setv) & 16'h8101;
      if (reg_wr && reg_addr == 4'h2) m_en = reg_wdata;
      if (reg_wr && reg_addr == 4'h4) m_ctl = reg_wdata & 16'hDFFF;
      if (apm_cmd_vld && apm_cmd == 8'hF1) m_ctl[0] = 1'b1;
      else if (apm_cmd_vld && apm_cmd == 8'hF0) m_ctl[0] = 1'b0;
      m_sts = nsts;
      if (tick_en) m_ticks++;
    end
    #1;
    if (rst_n && !done) begin
      chk(addr_tag(reg_addr), reg_rdata, m_read(reg_addr));
      chk("R5 sci level", 32'(sci_out), 32'(|(m_sts & m_en & 16'h0521)));
      chk("R7 shutdown pulse", 32'(shutdown_req), 32'(m_shut));
      chk("R8 reset pulse", 32'(reset_req), 32'(m_rst));
    end
  end

  logic s_shut, s_rst;

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    s_shut = shutdown_req; s_rst = reset_req;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp,
                    input logic [31:0] mask = 32'hFFFF_FFFF);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    chk(tag, reg_rdata & mask, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic apm(input logic [7:0] c);
    @(negedge clk);
    apm_cmd_vld = 1'b1; apm_cmd = c;
    @(negedge clk);
    apm_cmd_vld = 1'b0;
  endtask

  task automatic btn();
    @(negedge clk);
    pwr_btn_evt = 1'b1;
    @(negedge clk);
    pwr_btn_evt = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4'h0, "R1 status after reset", 32'h0);
    rd(4'h2, "R1 enable after reset", 32'h0);
    rd(4'h4, "R1 control after reset", 32'h0);
    rd(4'h8, "R1 timer after reset", 32'h0);
    chk("R1 sci after reset", 32'(sci_out), 32'h0);

    // R12: enable storage, unmapped offsets
    wr(4'h2, 16'h0101);
    rd(4'h2, "R12 enable readback", 32'h0101);
    rd(4'h6, "R12 unmapped 0x06", 32'h0);

    // R2: counting and ignored timer writes
    ticks(100);
    rd(4'h8, "R2 timer after 100 ticks", 32'd100);
    wr(4'h8, 16'hFFFF);
    rd(4'h8, "R2 timer write ignored", 32'd100);

    // R3: first overflow at half range
    ticks(411);
    rd(4'h0, "R3 flag before boundary", 32'h0);
    ticks(9);
    rd(4'h0, "R3 flag after boundary", 32'h1);
    chk("R5 sci with timer flag", 32'(sci_out), 32'h1);

    // R4: write 0 keeps, write 1 clears and re-arms past wrap
    wr(4'h0, 16'h0000);
    rd(4'h0, "R4 write zero keeps flag", 32'h1);
    wr(4'h0, 16'h0001);
    rd(4'h0, "R4 write one clears flag", 32'h0);
    chk("R5 sci drops", 32'(sci_out), 32'h0);
    ticks(WRAP - 520 - 1);
    rd(4'h0, "R4 no flag before wrapped target", 32'h0);
    ticks(1);
    rd(4'h8, "R2 timer wrapped", 32'h0);
    rd(4'h0, "R4 flag at wrapped target", 32'h1);
    wr(4'h0, 16'h0001);

    // R7 / R6: power-off sleep
    wr(4'h4, 16'h2000);
    chk("R7 shutdown pulse", 32'(s_shut), 32'h1);
    chk("R7 no reset on power-off", 32'(s_rst), 32'h0);
    rd(4'h4, "R6 sleep bit not stored", 32'h0);
    wr(4'h4, 16'h0C05);
    rd(4'h4, "R6 control stored", 32'h0C05);

    // R8: fake resume
    wr(4'h4, 16'h2400);
    chk("R8 reset pulse", 32'(s_rst), 32'h1);
    chk("R8 no shutdown on resume", 32'(s_shut), 32'h0);
    rd(4'h0, "R8 wake and button status", 32'h8100);
    chk("R5 sci with button status", 32'(sci_out), 32'h1);
    wr(4'h0, 16'h8100);

    // R9: other sleep types do nothing
    wr(4'h4, 16'h2C00);
    chk("R9 type 3 no pulse", 32'({s_shut, s_rst}), 32'h0);
    wr(4'h4, 16'h3C00);
    chk("R9 type 7 no pulse", 32'({s_shut, s_rst}), 32'h0);
    rd(4'h0, "R9 status untouched", 32'h0);

    // R10: APM strobe
    apm(8'hF1);
    rd(4'h4, "R10 F1 sets sci enable", 32'h1, 32'h1);
    apm(8'h55);
    rd(4'h4, "R10 other byte keeps", 32'h1, 32'h1);
    apm(8'hF0);
    rd(4'h4, "R10 F0 clears sci enable", 32'h0, 32'h1);

    // R11: power button gated by enable
    wr(4'h2, 16'h0000);
    btn();
    rd(4'h0, "R11 button ignored when disabled", 32'h0);
    wr(4'h2, 16'h0100);
    btn();
    rd(4'h0, "R11 button latched when enabled", 32'h0100);
    chk("R5 sci with button", 32'(sci_out), 32'h1);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick_en     = ($urandom % 4) != 0;
      reg_wr      = ($urandom % 6) == 0;
      case ($urandom % 6)
        0: reg_addr = 4'h0;
        1: reg_addr = 4'h2;
        2: reg_addr = 4'h4;
        3: reg_addr = 4'h8;
        4: reg_addr = 4'h6;
        default: reg_addr = 4'h0;
      endcase
      reg_wdata   = 16'($urandom);
      pwr_btn_evt = ($urandom % 16) == 0;
      apm_cmd_vld = ($urandom % 10) == 0;
      apm_cmd     = (($urandom % 2) == 0) ? (8'hF0 | 8'($urandom % 2)) : 8'($urandom);
    end
    @(negedge clk);
    tick_en = 0; reg_wr = 0; pwr_btn_evt = 0; apm_cmd_vld = 0;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule